// File: doc/BRIEF.md
# Dual-Channel Gate-DAC Code Register Bank

This block keeps the gate-bias DAC codes for two power-amplifier channels. Every channel owns three codes: a 10-bit fine code and two 8-bit coarse codes (an upper wiper and a lower wiper). Each code has a staging copy and a live copy. Only the live copy drives the DAC.

Software-side logic writes the block through a one-cycle write port. Each write carries a target selector, a channel number and a 16-bit data word. Three update paths exist:
- A staged write fills only the staging copy. A later load command copies the staging copies into the live copies.
- A pass-through write changes the live copy at once.
- A calibrating write also asks the calibration engine to run.

Each channel has a three-state calibration handshake machine with the states CAL_IDLE, CAL_REQ and CAL_WAIT:
- CAL_IDLE goes to CAL_REQ when a calibration start occurs.
- CAL_REQ always goes to CAL_WAIT on the next cycle.
- CAL_WAIT goes back to CAL_IDLE when the done input is sampled high.

The request output is high only in CAL_REQ. The busy output is high in CAL_REQ and in CAL_WAIT. A load command that arrives while a channel is busy is held for that channel and is carried out once the channel is idle again.

Top module: `gdac_code_bank`

## Requirements
- R1: After reset every live code is zero, busy and request are low on both channels, and the lower-wiper calibration flag is set while the upper-wiper flag is clear. So a load command issued right after reset starts calibration on both channels.
- R2: The staged targets write only the staging copy and leave the live code unchanged. These targets are 0 (fine), 4 (upper wiper) and 6 (lower wiper).
- R3: The pass-through targets write the staging copy and the live copy at the same clock edge. The live code is visible right after that edge. These targets are 1 (fine), 5 (upper wiper), 7 (lower wiper) and 3 (fine with calibration).
- R4: Data layout: the fine code is taken from data bits 9:0 and a wiper code from bits 7:0. Bit 15 of a wiper write is its calibration flag. All other data bits have no effect.
- R5: Targets 2 (staged fine) and 3 (pass-through fine) start calibration on an idle channel. The request output is then high for exactly one cycle, starting the cycle after the write, and busy rises together with it.
- R6: A pass-through wiper write (target 5 or 7) with bit 15 set starts calibration at once. With bit 15 clear, no calibration starts.
- R7: A staged wiper write (target 4 or 6) stores bit 15 as that wiper's flag and starts nothing. When a load copies a channel whose upper or lower flag is set, calibration starts on that channel and both of its flags clear.
- R8: Once a request has been made, busy stays high until the done input is sampled high in CAL_WAIT, and drops on the next cycle. The done input has no effect in CAL_IDLE or CAL_REQ.
- R9: Target 8 (load) copies all three codes of an idle channel at that edge. For a busy channel the load is held and is carried out one cycle after busy falls.
- R10: A calibration start on a busy channel makes no new request. The code update carried by the same write still takes effect.
- R11: Targets 9 to 15 change no code, flag, request or busy state.
- R12: A code write affects only the channel selected by the channel input (0 or 1). A load affects every channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe, one cycle per write |
| wr_target | input | 4 | Target selector (0 to 8 used) |
| wr_chan | input | 1 | Channel number of the write |
| wr_data | input | 16 | Write data word |
| cal_done | input | 2 | Per-channel calibration-done handshake |
| fine_code | output | 20 | Live fine codes, channel 0 in bits 9:0 |
| hi_code | output | 16 | Live upper-wiper codes, channel 0 in bits 7:0 |
| lo_code | output | 16 | Live lower-wiper codes, channel 0 in bits 7:0 |
| cal_req | output | 2 | Per-channel one-cycle calibration request |
| busy | output | 2 | Per-channel calibration-in-progress flag |

## Verification
The bench applies every one of the sixteen selector values on both channels. Each value is tried with five data words: all zeros, all ones, and mixes with and without bit 15 and with junk in the ignored bits. This separates the staged, pass-through and calibrating paths, and it shows that the unused selectors do nothing.

Each write is followed at once by a load command, so loads land on busy channels and the held-load path is exercised. The bench then answers every waiting request with a done pulse, which also covers calibrations that a load starts through a stored flag.

Directed sequences cover the rest:
- the lower-wiper flag that is set at reset;
- done pulses given while idle or while a request is still being raised;
- a second calibrating write given while a channel is busy.

// File: rtl/gdac_pkg.sv
package gdac_pkg;

    localparam int TGT_W = 4;

    typedef enum logic [TGT_W-1:0] {
        TGT_FINE_IN       = 4'd0,
        TGT_FINE_THRU     = 4'd1,
        TGT_FINE_CAL      = 4'd2,
        TGT_FINE_CAL_THRU = 4'd3,
        TGT_HI_IN         = 4'd4,
        TGT_HI_THRU       = 4'd5,
        TGT_LO_IN         = 4'd6,
        TGT_LO_THRU       = 4'd7,
        TGT_LOAD          = 4'd8
    } tgt_e;

    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_REQ  = 2'd1,
        CAL_WAIT = 2'd2
    } cal_st_e;

    typedef struct packed {
        logic fine_in;
        logic fine_out;
        logic fine_cal;
        logic hi_in;
        logic hi_out;
        logic hi_arm;
        logic lo_in;
        logic lo_out;
        logic lo_arm;
    } wr_strb_t;

endpackage

// File: rtl/gdac_wr_decode.sv
module gdac_wr_decode
    import gdac_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int CH_W = 1
) (
    input  logic                 wr_valid,
    input  logic [TGT_W-1:0]     wr_target,
    input  logic [CH_W-1:0]      wr_chan,
    output wr_strb_t [NCH-1:0]   chan_strb,
    output logic                 load_all
);

    wr_strb_t sel;

    always_comb begin
        sel      = '0;
        load_all = 1'b0;
        if (wr_valid) begin
            unique case (tgt_e'(wr_target))
                TGT_FINE_IN: begin
                    sel.fine_in = 1'b1;
                end
                TGT_FINE_THRU: begin
                    sel.fine_in  = 1'b1;
                    sel.fine_out = 1'b1;
                end
                TGT_FINE_CAL: begin
                    sel.fine_in  = 1'b1;
                    sel.fine_cal = 1'b1;
                end
                TGT_FINE_CAL_THRU: begin
                    sel.fine_in  = 1'b1;
                    sel.fine_out = 1'b1;
                    sel.fine_cal = 1'b1;
                end
                TGT_HI_IN: begin
                    sel.hi_in  = 1'b1;
                    sel.hi_arm = 1'b1;
                end
                TGT_HI_THRU: begin
                    sel.hi_in  = 1'b1;
                    sel.hi_out = 1'b1;
                end
                TGT_LO_IN: begin
                    sel.lo_in  = 1'b1;
                    sel.lo_arm = 1'b1;
                end
                TGT_LO_THRU: begin
                    sel.lo_in  = 1'b1;
                    sel.lo_out = 1'b1;
                end
                TGT_LOAD: begin
                    load_all = 1'b1;
                end
                default: begin
                    sel = '0;
                end
            endcase
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_route
        assign chan_strb[i] = (wr_chan == CH_W'(i)) ? sel : '0;
    end

endmodule

// File: rtl/gdac_cal_fsm.sv
module gdac_cal_fsm
    import gdac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cal_done,
    output logic cal_req,
    output logic busy,
    output logic idle
);

    cal_st_e st_q, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CAL_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_comb begin
        st_nxt  = st_q;
        cal_req = 1'b0;
        busy    = 1'b0;
        idle    = 1'b0;
        unique case (st_q)
            CAL_IDLE: begin
                idle = 1'b1;
                if (start) begin
                    st_nxt = CAL_REQ;
                end
            end
            CAL_REQ: begin
                cal_req = 1'b1;
                busy    = 1'b1;
                st_nxt  = CAL_WAIT;
            end
            CAL_WAIT: begin
                busy = 1'b1;
                if (cal_done) begin
                    st_nxt = CAL_IDLE;
                end
            end
            default: begin
                st_nxt = CAL_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/gdac_code_reg.sv
module gdac_code_reg #(
    parameter int W        = 8,
    parameter bit HAS_FLAG = 1'b1,
    parameter bit FLAG_RST = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wr_code,
    input  logic         in_we,
    input  logic         out_we,
    input  logic         copy,
    input  logic         arm_we,
    input  logic         wr_flag,
    input  logic         consume,
    output logic [W-1:0] code,
    output logic         flag
);

    logic [W-1:0] stage_q;
    logic [W-1:0] live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            live_q  <= '0;
        end else begin
            if (in_we) begin
                stage_q <= wr_code;
            end
            if (out_we) begin
                live_q <= wr_code;
            end else if (copy) begin
                live_q <= stage_q;
            end
        end
    end

    assign code = live_q;

    if (HAS_FLAG) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= FLAG_RST;
            end else if (arm_we) begin
                flag_q <= wr_flag;
            end else if (consume) begin
                flag_q <= 1'b0;
            end
        end
        assign flag = flag_q;
    end else begin : g_noflag
        logic unused_flag_in;
        assign unused_flag_in = arm_we ^ wr_flag ^ consume;
        assign flag = 1'b0;
    end

endmodule

// File: rtl/gdac_chan.sv
module gdac_chan
    import gdac_pkg::*;
#(
    parameter int FINE_W   = 10,
    parameter int COARSE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wr_strb_t            strb,
    input  logic                load_all,
    input  logic [FINE_W-1:0]   wr_fine,
    input  logic [COARSE_W-1:0] wr_coarse,
    input  logic                wr_flag,
    input  logic                cal_done,
    output logic [FINE_W-1:0]   fine_code,
    output logic [COARSE_W-1:0] hi_code,
    output logic [COARSE_W-1:0] lo_code,
    output logic                cal_req,
    output logic                busy
);

    logic idle;
    logic load_pend_q;
    logic do_copy;
    logic arm_cal;
    logic start;
    logic hi_flag;
    logic lo_flag;
    logic unused_fine_flag;

    assign do_copy = idle & (load_all | load_pend_q);
    assign arm_cal = do_copy & (hi_flag | lo_flag);
    assign start   = strb.fine_cal
                   | ((strb.hi_out | strb.lo_out) & wr_flag)
                   | arm_cal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_pend_q <= 1'b0;
        end else if (load_all && !idle) begin
            load_pend_q <= 1'b1;
        end else if (do_copy) begin
            load_pend_q <= 1'b0;
        end
    end

    gdac_code_reg #(.W(FINE_W), .HAS_FLAG(1'b0), .FLAG_RST(1'b0)) u_fine (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_code (wr_fine),
        .in_we   (strb.fine_in),
        .out_we  (strb.fine_out),
        .copy    (do_copy),
        .arm_we  (1'b0),
        .wr_flag (1'b0),
        .consume (1'b0),
        .code    (fine_code),
        .flag    (unused_fine_flag)
    );

    gdac_code_reg #(.W(COARSE_W), .HAS_FLAG(1'b1), .FLAG_RST(1'b0)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_code (wr_coarse),
        .in_we   (strb.hi_in),
        .out_we  (strb.hi_out),
        .copy    (do_copy),
        .arm_we  (strb.hi_arm),
        .wr_flag (wr_flag),
        .consume (arm_cal),
        .code    (hi_code),
        .flag    (hi_flag)
    );

    gdac_code_reg #(.W(COARSE_W), .HAS_FLAG(1'b1), .FLAG_RST(1'b1)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_code (wr_coarse),
        .in_we   (strb.lo_in),
        .out_we  (strb.lo_out),
        .copy    (do_copy),
        .arm_we  (strb.lo_arm),
        .wr_flag (wr_flag),
        .consume (arm_cal),
        .code    (lo_code),
        .flag    (lo_flag)
    );

    gdac_cal_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cal_done (cal_done),
        .cal_req  (cal_req),
        .busy     (busy),
        .idle     (idle)
    );

endmodule

// File: rtl/gdac_code_bank.sv
module gdac_code_bank
    import gdac_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int FINE_W   = 10,
    parameter int COARSE_W = 8,
    parameter int DATA_W   = 16,
    parameter int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [TGT_W-1:0]        wr_target,
    input  logic [CH_W-1:0]         wr_chan,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [NCH-1:0]          cal_done,
    output logic [NCH*FINE_W-1:0]   fine_code,
    output logic [NCH*COARSE_W-1:0] hi_code,
    output logic [NCH*COARSE_W-1:0] lo_code,
    output logic [NCH-1:0]          cal_req,
    output logic [NCH-1:0]          busy
);

    localparam int CAL_BIT = DATA_W - 1;

    wr_strb_t [NCH-1:0] chan_strb;
    logic               load_all;
    logic               unused_data;

    assign unused_data = ^wr_data[CAL_BIT-1:FINE_W];

    gdac_wr_decode #(.NCH(NCH), .CH_W(CH_W)) u_dec (
        .wr_valid  (wr_valid),
        .wr_target (wr_target),
        .wr_chan   (wr_chan),
        .chan_strb (chan_strb),
        .load_all  (load_all)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        gdac_chan #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .strb      (chan_strb[i]),
            .load_all  (load_all),
            .wr_fine   (wr_data[FINE_W-1:0]),
            .wr_coarse (wr_data[COARSE_W-1:0]),
            .wr_flag   (wr_data[CAL_BIT]),
            .cal_done  (cal_done[i]),
            .fine_code (fine_code[i*FINE_W +: FINE_W]),
            .hi_code   (hi_code[i*COARSE_W +: COARSE_W]),
            .lo_code   (lo_code[i*COARSE_W +: COARSE_W]),
            .cal_req   (cal_req[i]),
            .busy      (busy[i])
        );
    end

endmodule

// File: rtl/gdac_code_bank_chk.sv
module gdac_code_bank_chk #(
    parameter int NCH    = 2,
    parameter int FINE_W = 10,
    parameter int CH_W   = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_valid,
    input logic [3:0]            wr_target,
    input logic [CH_W-1:0]       wr_chan,
    input logic [FINE_W-1:0]     wr_fine,
    input logic [NCH-1:0]        cal_done,
    input logic [NCH*FINE_W-1:0] fine_code,
    input logic [NCH-1:0]        cal_req,
    input logic [NCH-1:0]        busy
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            cal_req[i] |=> !cal_req[i]); // R5
        AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            cal_req[i] |-> busy[i]); // R8
        AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[i] && !cal_done[i]) |=> busy[i]); // R8
        AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy[i]) |-> $past(cal_done[i])); // R8
        AST_FINE_THRU: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && wr_target == 4'd1 && wr_chan == CH_W'(i))
            |=> fine_code[i*FINE_W +: FINE_W] == $past(wr_fine)); // R3
        AST_FINE_CAL_START: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && (wr_target == 4'd2 || wr_target == 4'd3)
             && wr_chan == CH_W'(i) && !busy[i]) |=> cal_req[i]); // R5
        AST_NO_REREQ: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[i] && !cal_req[i]) |=> !cal_req[i]); // R10
    end

endmodule

bind gdac_code_bank gdac_code_bank_chk #(
    .NCH    (NCH),
    .FINE_W (FINE_W),
    .CH_W   (CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_target (wr_target),
    .wr_chan   (wr_chan),
    .wr_fine   (wr_data[FINE_W-1:0]),
    .cal_done  (cal_done),
    .fine_code (fine_code),
    .cal_req   (cal_req),
    .busy      (busy)
);

// File: tb/gdac_code_bank_bench.sv
`timescale 1ns/1ps
module gdac_code_bank_bench;

    localparam int NCH = 2;
    localparam int FW  = 10;
    localparam int CW  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              wr_valid;
    logic [3:0]        wr_target;
    logic [0:0]        wr_chan;
    logic [15:0]       wr_data;
    logic [NCH-1:0]    cal_done;
    logic [NCH*FW-1:0] fine_code;
    logic [NCH*CW-1:0] hi_code;
    logic [NCH*CW-1:0] lo_code;
    logic [NCH-1:0]    cal_req;
    logic [NCH-1:0]    busy;

    gdac_code_bank u_gdac_code_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_target (wr_target),
        .wr_chan   (wr_chan),
        .wr_data   (wr_data),
        .cal_done  (cal_done),
        .fine_code (fine_code),
        .hi_code   (hi_code),
        .lo_code   (lo_code),
        .cal_req   (cal_req),
        .busy      (busy)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    int m_fi [NCH];
    int m_fo [NCH];
    int m_hi [NCH];
    int m_ho [NCH];
    int m_li [NCH];
    int m_lo [NCH];
    bit m_hf [NCH];
    bit m_lf [NCH];
    bit m_pd [NCH];
    int m_st [NCH];

    logic [15:0] pats [5] = '{16'h0000, 16'hFFFF, 16'h8155, 16'h7EAA, 16'h03C3};

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_fi[c] = 0; m_fo[c] = 0; m_hi[c] = 0; m_ho[c] = 0;
            m_li[c] = 0; m_lo[c] = 0; m_hf[c] = 0; m_lf[c] = 1;
            m_pd[c] = 0; m_st[c] = 0;
        end
    endtask

    task automatic model_step(bit v, int t, int ch_sel, logic [15:0] d, logic [1:0] dn);
        int  fv;
        int  cv;
        bit  flg;
        bit  ld;
        fv  = int'(d[9:0]);
        cv  = int'(d[7:0]);
        flg = d[15];
        ld  = v && (t == 8);
        for (int c = 0; c < NCH; c++) begin
            bit sel, fin, fout, fcal, hin, hout, harm, lin, lout, larm;
            bit idle, cpy, arm, start;
            sel  = v && (ch_sel == c);
            fin  = sel && (t >= 0 && t <= 3);
            fout = sel && (t == 1 || t == 3);
            fcal = sel && (t == 2 || t == 3);
            hin  = sel && (t == 4 || t == 5);
            hout = sel && (t == 5);
            harm = sel && (t == 4);
            lin  = sel && (t == 6 || t == 7);
            lout = sel && (t == 7);
            larm = sel && (t == 6);
            idle  = (m_st[c] == 0);
            cpy   = idle && (ld || m_pd[c]);
            arm   = cpy && (m_hf[c] || m_lf[c]);
            start = fcal || ((hout || lout) && flg) || arm;
            if (fout) m_fo[c] = fv; else if (cpy) m_fo[c] = m_fi[c];
            if (hout) m_ho[c] = cv; else if (cpy) m_ho[c] = m_hi[c];
            if (lout) m_lo[c] = cv; else if (cpy) m_lo[c] = m_li[c];
            if (fin) m_fi[c] = fv;
            if (hin) m_hi[c] = cv;
            if (lin) m_li[c] = cv;
            if (harm) m_hf[c] = flg; else if (arm) m_hf[c] = 1'b0;
            if (larm) m_lf[c] = flg; else if (arm) m_lf[c] = 1'b0;
            if (ld && !idle) m_pd[c] = 1'b1; else if (cpy) m_pd[c] = 1'b0;
            case (m_st[c])
                0: m_st[c] = start ? 1 : 0;
                1: m_st[c] = 2;
                default: m_st[c] = dn[c] ? 0 : 2;
            endcase
        end
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(tag, $sformatf("ch%0d fine", c), int'(fine_code[c*FW +: FW]), m_fo[c]);
            chk(tag, $sformatf("ch%0d hi", c), int'(hi_code[c*CW +: CW]), m_ho[c]);
            chk(tag, $sformatf("ch%0d lo", c), int'(lo_code[c*CW +: CW]), m_lo[c]);
            chk(tag, $sformatf("ch%0d busy", c), int'(busy[c]), (m_st[c] != 0) ? 1 : 0);
            chk(tag, $sformatf("ch%0d req", c), int'(cal_req[c]), (m_st[c] == 1) ? 1 : 0);
        end
    endtask

    task automatic step(bit v, int t, int c, logic [15:0] d, logic [1:0] dn, string tag);
        @(negedge clk);
        wr_valid  = v;
        wr_target = t[3:0];
        wr_chan   = c[0:0];
        wr_data   = d;
        cal_done  = dn;
        @(posedge clk);
        model_step(v, t, c, d, dn);
        #2;
        check_all(tag);
    endtask

    function automatic logic [1:0] wait_mask();
        return {m_st[1] == 2, m_st[0] == 2};
    endfunction

    task automatic drain(string tag);
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 0, 0, 16'h0000, wait_mask(), tag);
        end
    endtask

    function automatic string tag_for(int t);
        if (t == 0 || t == 4 || t == 6) return "R2";
        if (t == 1) return "R3";
        if (t == 2 || t == 3) return "R5";
        if (t == 5 || t == 7) return "R6";
        if (t == 8) return "R12";
        return "R11";
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        wr_valid  = 1'b0;
        wr_target = 4'd0;
        wr_chan   = 1'b0;
        wr_data   = 16'h0000;
        cal_done  = 2'b00;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, then load triggers cal through the armed low flag
        step(1'b0, 0, 0, 16'h0000, 2'b00, "R1");
        step(1'b1, 8, 0, 16'h0000, 2'b00, "R1");
        drain("R1");

        // R4: ignored bits in fine and wiper writes
        step(1'b1, 1, 0, 16'hFEA5, 2'b00, "R4");
        step(1'b1, 5, 0, 16'h7F3C, 2'b00, "R4");
        step(1'b1, 7, 1, 16'h40C7, 2'b00, "R4");
        drain("R4");

        // R8: done while idle and while requesting has no effect
        step(1'b0, 0, 0, 16'h0000, 2'b11, "R8");
        step(1'b1, 2, 0, 16'h0123, 2'b00, "R8");
        step(1'b0, 0, 0, 16'h0000, 2'b01, "R8");
        step(1'b0, 0, 0, 16'h0000, 2'b00, "R8");
        drain("R8");

        // R10: second calibrating write while busy
        step(1'b1, 2, 1, 16'h0011, 2'b00, "R10");
        step(1'b1, 3, 1, 16'h0122, 2'b00, "R10");
        step(1'b1, 7, 1, 16'h8033, 2'b00, "R10");
        drain("R10");

        // R7: staged wiper flag arms a load-time calibration
        step(1'b1, 4, 0, 16'h805A, 2'b00, "R7");
        step(1'b1, 8, 0, 16'h0000, 2'b00, "R7");
        drain("R7");

        // R12: write on channel 1 leaves channel 0 alone
        step(1'b1, 5, 1, 16'h00AB, 2'b00, "R12");
        drain("R12");

        // Sweep: every selector, both channels, five data words, load, answer
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t < 16; t++) begin
                for (int p = 0; p < 5; p++) begin
                    step(1'b1, t, c, pats[p], 2'b00, tag_for(t));
                    step(1'b1, 8, 0, 16'h0000, 2'b00, "R9");
                    drain("R8");
                end
            end
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule